// File: doc/BRIEF.md
# ROM-Coupled Accumulating Register File

This block is a small memory subsystem that pairs a fixed table of constants with a writable store. Both are selected by one shared address. When a write is enabled, the word written into the addressed store entry is built from the input word and the constant at that address. A 2-bit operation code selects how it is built: the input plus the constant, the input minus the constant, all zeros, or all ones.

The store entry at the current address always drives the read output combinationally. The constant at the current address drives a second output, also without a clock. A surrounding design uses the block to keep running counters or tallies. Each tally is adjusted by a per-slot step that is fixed when the design is elaborated. The same path can also clear a slot or saturate it to all ones.

Top module: `romacc_store`

## Requirements
- R1: A synchronous active-high `rst` sampled on a rising edge sets every store entry to 0x00.
- R2: Constant-table entry i holds (37*i + 3) mod 256. `k_out` shows the entry at `addr` combinationally, with no clock edge needed. For i = 0..7 the values are 0x03, 0x28, 0x4D, 0x72, 0x97, 0xBC, 0xE1, 0x06.
- R3: With `wr_en`=1 and `op`=2'b00, the rising edge stores (din + constant[addr]) mod 256 into entry `addr`. No carry is kept.
- R4: With `wr_en`=1 and `op`=2'b01, the rising edge stores (din - constant[addr]) mod 256 into entry `addr`. No borrow is kept.
- R5: With `wr_en`=1 and `op`=2'b10, the rising edge stores 0x00 into entry `addr`, whatever the value of `din`.
- R6: With `wr_en`=1 and `op`=2'b11, the rising edge stores 0xFF into entry `addr`, whatever the value of `din`.
- R7: With `wr_en`=0, no entry changes on a rising edge, whatever the values of `op` and `din`.
- R8: A write changes only the entry selected by `addr`. All other entries keep their values.
- R9: `dout` shows store entry `addr` combinationally. A new address is reflected without a clock edge, and a written value appears right after its edge.
- R10: When `rst` and `wr_en` are both high on the same edge, the reset wins and the addressed entry becomes 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for store writes |
| rst | input | 1 | Synchronous active-high clear of the store |
| wr_en | input | 1 | Write enable; low leaves the store unchanged |
| op | input | 2 | Write operation: 00 add, 01 subtract, 10 clear, 11 preset |
| addr | input | 3 | Shared address for the constant table and the store |
| din | input | 8 | Input word combined with the constant |
| k_out | output | 8 | Constant at `addr` (combinational) |
| dout | output | 8 | Store entry at `addr` (combinational) |

## Verification
The bench targets the cases where the sum or difference wraps past 255 or below 0. A design that kept a ninth bit there, or that saturated instead of wrapping, would store a wrong word. It also writes with `wr_en` low while `op` selects preset. A design that gated on the opcode alone would then overwrite the entry with 0xFF. After a single write it reads every other entry back, which exposes a broken address decode that hits several entries or the wrong one. Finally, it raises reset together with a write. A design that gave the write priority would leave 0xFF behind where 0x00 is expected.

// File: rtl/romacc_pkg.sv
package romacc_pkg;

    localparam int DATA_W  = 8;
    localparam int DEPTH   = 8;
    localparam int ADDR_W  = $clog2(DEPTH);
    localparam int LUT_MUL = 37;
    localparam int LUT_ADD = 3;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_CLR = 2'b10,
        OP_SET = 2'b11
    } acc_op_e;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] idx;
        logic [DATA_W-1:0] word;
    } wr_req_t;

endpackage

// File: rtl/romacc_lut.sv
module romacc_lut
    import romacc_pkg::*;
#(
    parameter int W     = DATA_W,
    parameter int N     = DEPTH,
    parameter int AW    = $clog2(N),
    parameter int MUL   = LUT_MUL,
    parameter int OFS   = LUT_ADD
) (
    input  logic [AW-1:0] sel,
    output logic [W-1:0]  word
);

    logic [W-1:0] table_q [N];

    for (genvar i = 0; i < N; i++) begin : g_const
        assign table_q[i] = W'(i * MUL + OFS);
    end

    assign word = table_q[sel];

endmodule

// File: rtl/romacc_opmux.sv
module romacc_opmux
    import romacc_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  acc_op_e      mode,
    input  logic [W-1:0] a,
    input  logic [W-1:0] k,
    output logic [W-1:0] y
);

    always_comb begin
        unique case (mode)
            OP_ADD:  y = a + k;
            OP_SUB:  y = a - k;
            OP_CLR:  y = '0;
            default: y = '1;
        endcase
    end

endmodule

// File: rtl/romacc_bank.sv
module romacc_bank
    import romacc_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int N  = DEPTH,
    parameter int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  wr_req_t       req,
    input  logic [AW-1:0] rd_sel,
    output logic [W-1:0]  rd_word
);

    logic [W-1:0] cell_q [N];

    for (genvar i = 0; i < N; i++) begin : g_cell
        logic hit;
        assign hit = req.en && (req.idx == AW'(i));
        always_ff @(posedge clk) begin
            if (rst) begin
                cell_q[i] <= '0;
            end else if (hit) begin
                cell_q[i] <= req.word;
            end
        end
    end

    assign rd_word = cell_q[rd_sel];

endmodule

// File: rtl/romacc_store.sv
module romacc_store
    import romacc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] k_out,
    output logic [DATA_W-1:0] dout
);

    logic [DATA_W-1:0] k_w;
    logic [DATA_W-1:0] next_w;
    wr_req_t           req;

    romacc_lut #(.W(DATA_W), .N(DEPTH), .AW(ADDR_W)) u_lut (
        .sel  (addr),
        .word (k_w)
    );

    romacc_opmux #(.W(DATA_W)) u_mux (
        .mode (acc_op_e'(op)),
        .a    (din),
        .k    (k_w),
        .y    (next_w)
    );

    assign req.en   = wr_en;
    assign req.idx  = addr;
    assign req.word = next_w;

    romacc_bank #(.W(DATA_W), .N(DEPTH), .AW(ADDR_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .rd_sel  (addr),
        .rd_word (dout)
    );

    assign k_out = k_w;

endmodule

// File: rtl/romacc_store_chk.sv
module romacc_store_chk
    import romacc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [1:0]        op,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] din,
    input logic [DATA_W-1:0] k_out,
    input logic [DATA_W-1:0] dout
);

    p_clear_on_reset_r1: assert property (@(posedge clk)
        rst |=> dout == '0);

    p_const_steady_r2: assert property (@(posedge clk) disable iff (rst)
        $stable(addr) |-> $stable(k_out));

    p_add_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && op == 2'b00) |=>
            (addr != $past(addr)) || (dout == DATA_W'($past(din) + $past(k_out))));

    p_sub_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && op == 2'b01) |=>
            (addr != $past(addr)) || (dout == DATA_W'($past(din) - $past(k_out))));

    p_clear_op_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && op == 2'b10) |=> (addr != $past(addr)) || (dout == '0));

    p_preset_op_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && op == 2'b11) |=> (addr != $past(addr)) || (dout == '1));

    p_hold_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> (addr != $past(addr)) || (dout == $past(dout)));

endmodule

bind romacc_store romacc_store_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_en),
    .op    (op),
    .addr  (addr),
    .din   (din),
    .k_out (k_out),
    .dout  (dout)
);

// File: tb/sim_romacc_store.sv
`timescale 1ns/1ps
module sim_romacc_store;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] op = 2'b00;
    logic [2:0] addr = 3'd0;
    logic [7:0] din = 8'h00;
    logic [7:0] k_out;
    logic [7:0] dout;

    int n_run  = 0;
    int n_fail = 0;
    logic [7:0] model [8];

    always #10 clk = ~clk;

    romacc_store u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .op(op),
        .addr(addr), .din(din), .k_out(k_out), .dout(dout)
    );

    function automatic logic [7:0] kconst(input int i);
        int t;
        t = (37 * i + 3) % 256;
        return t[7:0];
    endfunction

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic do_write(input logic [2:0] a, input logic [1:0] o,
                            input logic [7:0] d, input logic en);
        @(negedge clk);
        addr = a; op = o; din = d; wr_en = en;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    task automatic read_all(input string tag);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            addr = 3'(i);
            #1;
            chk(tag, dout, model[i]);
        end
    endtask

    task automatic t_reset;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 8; i++) model[i] = 8'h00;
        read_all("R1 reset clears store");
    endtask

    task automatic t_lut;
        for (int i = 0; i < 8; i++) begin
            addr = 3'(7 - i);
            #2;
            chk("R2 constant table", k_out, kconst(7 - i));
        end
    endtask

    task automatic t_add;
        do_write(3'd7, 2'b00, 8'hFB, 1'b1);
        model[7] = 8'(8'hFB + kconst(7));
        chk("R3 add wraps", dout, model[7]);
        do_write(3'd4, 2'b00, 8'd200, 1'b1);
        model[4] = 8'(8'd200 + kconst(4));
        chk("R3 add wraps", dout, model[4]);
        do_write(3'd0, 2'b00, 8'h10, 1'b1);
        model[0] = 8'(8'h10 + kconst(0));
        chk("R3 add plain", dout, model[0]);
    endtask

    task automatic t_sub;
        do_write(3'd1, 2'b01, 8'd10, 1'b1);
        model[1] = 8'(8'd10 - kconst(1));
        chk("R4 sub borrow wraps", dout, model[1]);
        do_write(3'd6, 2'b01, 8'hF0, 1'b1);
        model[6] = 8'(8'hF0 - kconst(6));
        chk("R4 sub plain", dout, model[6]);
    endtask

    task automatic t_clr_set;
        do_write(3'd2, 2'b11, 8'h5A, 1'b1);
        model[2] = 8'hFF;
        chk("R6 preset", dout, 8'hFF);
        do_write(3'd2, 2'b10, 8'hA5, 1'b1);
        model[2] = 8'h00;
        chk("R5 clear", dout, 8'h00);
        do_write(3'd3, 2'b11, 8'h00, 1'b1);
        model[3] = 8'hFF;
        chk("R6 preset", dout, 8'hFF);
    endtask

    task automatic t_hold;
        do_write(3'd0, 2'b11, 8'h77, 1'b0);
        chk("R7 idle preset ignored", dout, model[0]);
        do_write(3'd3, 2'b10, 8'h12, 1'b0);
        chk("R7 idle clear ignored", dout, model[3]);
        read_all("R7 store unchanged");
    endtask

    task automatic t_isolate;
        do_write(3'd5, 2'b11, 8'h00, 1'b1);
        model[5] = 8'hFF;
        read_all("R8 other entries kept");
    endtask

    task automatic t_comb_read;
        @(negedge clk);
        addr = 3'd5; #1;
        chk("R9 read follows addr", dout, model[5]);
        addr = 3'd1; #1;
        chk("R9 read follows addr", dout, model[1]);
    endtask

    task automatic t_reset_wins;
        @(negedge clk);
        addr = 3'd4; op = 2'b11; din = 8'h33; wr_en = 1'b1; rst = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rst = 1'b0;
        #1;
        chk("R10 reset beats write", dout, 8'h00);
        for (int i = 0; i < 8; i++) model[i] = 8'h00;
        read_all("R10 all clear after reset");
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_lut();
        t_add();
        t_sub();
        t_clr_set();
        t_hold();
        t_isolate();
        t_comb_read();
        t_reset_wins();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule